// File: doc/BRIEF.md
# Dual-Clock Fast-Capture Input Path

This block is the storage part of a single pad's input path. Pad data can first be caught by an early capture latch. That latch is timed by the clock that drives the pad's output register, not by the input clock. A second storage element then hands the value to logic on the input clock. This lets a design sample a fast-moving pad near the output clock and still deliver it in the input-clock domain.

The second element is chosen by a static configuration bit. It is either an edge-triggered flip-flop or a level-sensitive latch. Each clock has its own polarity bit, and the early latch can be left out of the path. A clock enable gates the second element. An asynchronous global set/reset loads it with a configured value. A raw copy of the pad is always available alongside the stored value.

Top module: `fastcap_input_path`

## Requirements
- R1: With `cfg_cap_en`=1 and `cfg_oclk_inv`=0, the capture latch passes `pad_i` while `oclk_i` is 0 and holds its value while `oclk_i` is 1. The input clock has no effect on this latch.
- R2: With `cfg_oclk_inv`=1, the capture latch timing is reversed. It passes data while `oclk_i` is 1 and holds while `oclk_i` is 0.
- R3: With `cfg_latch_mode`=0, `data_o` takes the second-stage input only on a rising edge of the effective input clock. It does not follow data changes while that clock stays high.
- R4: With `cfg_latch_mode`=1, `data_o` follows the second-stage input while the effective input clock is 1. It holds while that clock is 0.
- R5: With `cfg_iclk_inv`=1, the effective input clock is `iclk_i` inverted. In flip-flop mode, a falling edge of `iclk_i` samples and a rising edge does not.
- R6: With `cfg_cap_en`=0, `pad_i` feeds the second element directly. With `cfg_cap_en`=1, the capture latch output feeds it.
- R7: While `ce_i`=0, the second element keeps its value in both modes.
- R8: While `gsr_i`=1, `data_o` equals `cfg_gsr_val` on every bit. This happens asynchronously and overrides both clocks and `ce_i`.
- R9: `raw_o` equals `pad_i` at all times, whatever the clocks and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pad_i | input | W | Data from the pad |
| oclk_i | input | 1 | Output-side clock, times the capture latch |
| iclk_i | input | 1 | Input-side clock, times the second element |
| ce_i | input | 1 | Clock enable of the second element |
| gsr_i | input | 1 | Asynchronous global set/reset, active high |
| cfg_cap_en | input | 1 | 1 puts the capture latch in the path |
| cfg_oclk_inv | input | 1 | 1 inverts the output-side clock |
| cfg_iclk_inv | input | 1 | 1 inverts the input-side clock |
| cfg_latch_mode | input | 1 | 0 selects a flip-flop, 1 selects a latch as the second element |
| cfg_gsr_val | input | 1 | Value loaded by global set/reset (0 = reset) |
| data_o | output | W | Stored data in the input-clock domain |
| raw_o | output | W | Unstored copy of the pad |

## Verification
The assertions check three things at every input-clock edge. A held global set/reset shows its configured value. A disabled flip-flop keeps its value across a clock period. An enabled flip-flop with the capture latch bypassed shows the pad value seen at the rising edge. A further assertion checks that an open second-stage latch with bypassed capture shows the pad. Some behaviour shows only through the bench's orderings of clock and data changes:
- the capture latch holding against pad changes under both output-clock polarities;
- the falling-edge sampling under input-clock inversion;
- the flip-flop ignoring data during its high phase.

// File: rtl/fastcap_input_path.sv
module fastcap_input_path #(
  parameter int W = 1
) (
  input  logic [W-1:0] pad_i,
  input  logic         oclk_i,
  input  logic         iclk_i,
  input  logic         ce_i,
  input  logic         gsr_i,
  input  logic         cfg_cap_en,
  input  logic         cfg_oclk_inv,
  input  logic         cfg_iclk_inv,
  input  logic         cfg_latch_mode,
  input  logic         cfg_gsr_val,
  output logic [W-1:0] data_o,
  output logic [W-1:0] raw_o
);

  logic         oclk_eff;
  logic         iclk_eff;
  logic [W-1:0] cap_q;
  logic [W-1:0] stage_d;
  logic [W-1:0] ff_q;
  logic [W-1:0] lat_q;

  assign oclk_eff = oclk_i ^ cfg_oclk_inv;
  assign iclk_eff = iclk_i ^ cfg_iclk_inv;

  // early capture: open while the effective output clock is low
  always_latch begin
    if (!oclk_eff) cap_q <= pad_i;
  end

  assign stage_d = cfg_cap_en ? cap_q : pad_i;

  always_ff @(posedge iclk_eff or posedge gsr_i) begin
    if (gsr_i)     ff_q <= {W{cfg_gsr_val}};
    else if (ce_i) ff_q <= stage_d;
  end

  always_latch begin
    if (gsr_i)                 lat_q <= {W{cfg_gsr_val}};
    else if (iclk_eff && ce_i) lat_q <= stage_d;
  end

  assign data_o = cfg_latch_mode ? lat_q : ff_q;
  assign raw_o  = pad_i;

endmodule

module fastcap_input_path_chk #(
  parameter int W = 1
) (
  input logic [W-1:0] pad_i,
  input logic         oclk_i,
  input logic         iclk_i,
  input logic         ce_i,
  input logic         gsr_i,
  input logic         cfg_cap_en,
  input logic         cfg_oclk_inv,
  input logic         cfg_iclk_inv,
  input logic         cfg_latch_mode,
  input logic         cfg_gsr_val,
  input logic [W-1:0] data_o,
  input logic [W-1:0] raw_o
);

  logic         gsr_seen;
  logic         ce_rise;
  logic [W-1:0] pad_rise;

  always_ff @(negedge iclk_i or posedge gsr_i) begin
    if (gsr_i) gsr_seen <= 1'b1;
    else       gsr_seen <= 1'b0;
  end

  always_ff @(posedge iclk_i) begin
    ce_rise  <= ce_i;
    pad_rise <= pad_i;
  end

  always @(posedge iclk_i) begin
    if (gsr_i) begin
      AST_GSR_FORCE: assert (data_o == {W{cfg_gsr_val}}) // R8
        else $error("gsr value not forced");
    end
  end

  AST_CE_HOLD: assert property (@(negedge iclk_i) disable iff (gsr_i)
    (!gsr_seen && !cfg_latch_mode && $stable(cfg_latch_mode) && !cfg_iclk_inv &&
     $stable(cfg_iclk_inv) && !ce_rise) |-> $stable(data_o)) // R7
    else $error("disabled flip-flop changed");

  AST_FF_SAMPLE: assert property (@(negedge iclk_i) disable iff (gsr_i)
    (!gsr_seen && !cfg_latch_mode && $stable(cfg_latch_mode) && !cfg_iclk_inv &&
     $stable(cfg_iclk_inv) && ce_rise && !cfg_cap_en && $stable(cfg_cap_en))
    |-> (data_o == pad_rise)) // R3
    else $error("flip-flop missed rising-edge sample");

  AST_LATCH_OPEN: assert property (@(negedge iclk_i) disable iff (gsr_i)
    (cfg_latch_mode && !cfg_iclk_inv && !cfg_cap_en && ce_i) |-> (data_o == pad_i)) // R4
    else $error("open latch not following pad");

endmodule

bind fastcap_input_path fastcap_input_path_chk #(.W(W)) u_chk (.*);

// File: tb/fastcap_input_path_bench.sv
module fastcap_input_path_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [0:0] pad_i;
  logic oclk_i, iclk_i, ce_i, gsr_i;
  logic cfg_cap_en, cfg_oclk_inv, cfg_iclk_inv, cfg_latch_mode, cfg_gsr_val;
  logic [0:0] data_o, raw_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  fastcap_input_path #(.W(1)) u_fastcap_input_path (
    .pad_i(pad_i), .oclk_i(oclk_i), .iclk_i(iclk_i), .ce_i(ce_i), .gsr_i(gsr_i),
    .cfg_cap_en(cfg_cap_en), .cfg_oclk_inv(cfg_oclk_inv), .cfg_iclk_inv(cfg_iclk_inv),
    .cfg_latch_mode(cfg_latch_mode), .cfg_gsr_val(cfg_gsr_val),
    .data_o(data_o), .raw_o(raw_o)
  );

  // {latch_mode, cap_en, oclk_inv, iclk_inv, pad, expected}
  localparam logic [5:0] VEC [12] = '{
    6'b000010, 6'b010000, 6'b011011, 6'b000101, 6'b010111, 6'b001110,
    6'b100011, 6'b110000, 6'b100100, 6'b111111, 6'b101000, 6'b111000
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic gsr_pulse(input logic v);
    cfg_gsr_val = v; #1;
    gsr_i = 1'b1; #2;
    gsr_i = 1'b0; #2;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cfg_gsr_val = 1'b0; cfg_cap_en = 1'b0; cfg_oclk_inv = 1'b0; cfg_iclk_inv = 1'b0;
    cfg_latch_mode = 1'b0; ce_i = 1'b1; iclk_i = 1'b0; oclk_i = 1'b0; pad_i = 1'b1;
    gsr_i = 1'b0; #1;
    gsr_i = 1'b1; #2;

    // R8 reset state and override
    chk("R8 reset value 0", data_o[0], 1'b0);
    chk("R9 raw follows pad", raw_o[0], 1'b1);
    iclk_i = 1'b1; #2;
    chk("R8 clock ignored under gsr", data_o[0], 1'b0);
    iclk_i = 1'b0; #2;
    gsr_i = 1'b0; #2;
    cfg_gsr_val = 1'b1; #1;
    gsr_i = 1'b1; #2;
    chk("R8 set value 1 ff", data_o[0], 1'b1);
    cfg_latch_mode = 1'b1; iclk_i = 1'b1; pad_i = 1'b0; #2;
    chk("R8 latch forced while open", data_o[0], 1'b1);
    gsr_i = 1'b0; #2;
    chk("R4 open latch follows", data_o[0], 1'b0);
    pad_i = 1'b1; #2;
    chk("R4 open latch follows rise", data_o[0], 1'b1);
    iclk_i = 1'b0; #2;
    pad_i = 1'b0; #2;
    chk("R4 closed latch holds", data_o[0], 1'b1);

    // R7 clock enable
    ce_i = 1'b0; iclk_i = 1'b1; #2;
    chk("R7 latch holds with ce low", data_o[0], 1'b1);
    iclk_i = 1'b0; #2;
    gsr_pulse(1'b0);
    cfg_latch_mode = 1'b0; pad_i = 1'b1; #2;
    iclk_i = 1'b1; #2;
    chk("R7 ff holds with ce low", data_o[0], 1'b0);
    iclk_i = 1'b0; #2;
    ce_i = 1'b1; #2;
    iclk_i = 1'b1; #2;
    chk("R3 ff samples on rise", data_o[0], 1'b1);
    iclk_i = 1'b0; #2;

    // R3 edge only
    pad_i = 1'b0; #1;
    iclk_i = 1'b1; #2;
    chk("R3 ff samples low", data_o[0], 1'b0);
    pad_i = 1'b1; #2;
    chk("R3 ff ignores high-phase change", data_o[0], 1'b0);
    iclk_i = 1'b0; #2;

    // R5 input clock inversion
    cfg_iclk_inv = 1'b1; #2;
    iclk_i = 1'b1; #2;
    pad_i = 1'b0; #2;
    iclk_i = 1'b0; #2;
    chk("R5 falling raw edge samples", data_o[0], 1'b0);
    pad_i = 1'b1; #1;
    iclk_i = 1'b1; #2;
    chk("R5 rising raw edge ignored", data_o[0], 1'b0);
    cfg_iclk_inv = 1'b0; #2;
    iclk_i = 1'b0; #2;

    // R1 and R2 capture latch
    cfg_latch_mode = 1'b1; cfg_cap_en = 1'b1; cfg_oclk_inv = 1'b0; #1;
    gsr_pulse(1'b0);
    oclk_i = 1'b0; iclk_i = 1'b1; pad_i = 1'b1; #2;
    chk("R1 capture open while oclk low", data_o[0], 1'b1);
    pad_i = 1'b0; #2;
    chk("R1 capture open passes fall", data_o[0], 1'b0);
    oclk_i = 1'b1; #2;
    pad_i = 1'b1; #2;
    chk("R1 capture holds while oclk high", data_o[0], 1'b0);
    oclk_i = 1'b0; #2;
    chk("R1 capture reopens", data_o[0], 1'b1);
    cfg_oclk_inv = 1'b1; #2;
    pad_i = 1'b0; #2;
    chk("R2 inverted holds while oclk low", data_o[0], 1'b1);
    oclk_i = 1'b1; #2;
    chk("R2 inverted open while oclk high", data_o[0], 1'b0);
    iclk_i = 1'b0; #2;

    // table: R1 R2 R3 R4 R5 R6 R9 across configurations
    for (int i = 0; i < 12; i++) begin
      logic [5:0] v;
      v = VEC[i];
      cfg_gsr_val = ~v[0]; #1;
      gsr_i = 1'b1; #1;
      cfg_latch_mode = v[5]; cfg_cap_en = v[4]; cfg_oclk_inv = v[3]; cfg_iclk_inv = v[2];
      oclk_i = v[3]; iclk_i = v[2]; ce_i = 1'b1; pad_i = v[1]; #2;
      gsr_i = 1'b0; #2;
      oclk_i = ~v[3]; #2;
      pad_i = ~v[1]; #2;
      iclk_i = ~v[2]; #2;
      pad_i = v[1]; #2;
      iclk_i = v[2]; #2;
      pad_i = ~v[1]; #2;
      chk($sformatf("R6 R1 R2 R3 R4 R5 vector %0d", i), data_o[0], v[0]);
      chk($sformatf("R9 raw vector %0d", i), raw_o[0], ~v[1]);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule